// File: doc/BRIEF.md
# Byte Register File with Address Pointer Pairs

This block is the working register store of a small 8-bit processor core. It holds thirty-two byte-wide registers. Two read ports are purely combinational, so an ALU can fetch both operands, compute and return its result through the single byte write port inside one clock cycle. The top six registers also act as three 16-bit address pointers, named X, Y and Z. Each pair has a low byte and a high byte. A dedicated update path can step one pointer per cycle, either incrementing it after use or decrementing it before use. The block drives out the effective address for the current access. The Z pointer is also driven out as a program-memory lookup address.

The whole file is also visible in the low part of a linear data address space. A load/store port can read or write any register by address. Addresses from 0x20 upward belong to the I/O region, and the file ignores them. A word write port loads both bytes of any even-aligned register pair in one cycle. When several write sources hit the same byte in one cycle, a fixed priority decides which one wins. There is no state machine: every cycle is a single write-back step. The update source for each byte is picked by an enumerated priority chain.

Top module: `gpr_file`

## Requirements
- R1: After reset every register reads as 0x00 on every read port and on every pointer output.
- R2: Both read ports are combinational. A read of the register being written in the same cycle returns the old value, and the new value appears after the clock edge.
- R3: When wr_en is high, wr_data is stored into register wr_addr at the clock edge.
- R4: ptr_x is {R27,R26}, ptr_y is {R29,R28} and ptr_z is {R31,R30}, with the lower-numbered register as the low byte.
- R5: With ptr_op = 1 (post-increment), ptr_addr equals the selected pointer during the cycle and the pointer becomes value+1 afterwards. The carry crosses into the high byte, and 0xFFFF wraps to 0x0000. ptr_sel encodes X=0, Y=1, Z=2 and none=3.
- R6: With ptr_op = 2 (pre-decrement), ptr_addr equals the selected pointer minus one, and the pointer takes that value. The borrow crosses bytes, and 0x0000 wraps to 0xFFFF.
- R7: Per byte, the write priority is ALU write > word write > data-port store > pointer update. A losing source leaves the other bytes it targets intact.
- R8: When ww_en is high, ww_data[7:0] goes into register 2*ww_pair and ww_data[15:8] goes into register 2*ww_pair+1.
- R9: A data address 0x00–0x1F raises dp_hit and makes dp_rdata the addressed register. A store with dp_we writes dp_wdata to that register.
- R10: A data address of 0x20 or above gives dp_hit = 0 and dp_rdata = 0x00, and a store to it changes no register.
- R11: prog_addr always equals the current Z pointer.
- R12: ptr_op 0 or 3, or ptr_sel = 3, leaves all three pointers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rs1_addr | input | 5 | Operand A register index |
| rs1_data | output | 8 | Operand A value |
| rs2_addr | input | 5 | Operand B register index |
| rs2_data | output | 8 | Operand B value |
| wr_en | input | 1 | ALU result write enable |
| wr_addr | input | 5 | ALU result register index |
| wr_data | input | 8 | ALU result byte |
| ww_en | input | 1 | Pair word write enable |
| ww_pair | input | 4 | Pair index (registers 2n, 2n+1) |
| ww_data | input | 16 | Pair word value |
| ptr_sel | input | 2 | Pointer select: 0 X, 1 Y, 2 Z, 3 none |
| ptr_op | input | 2 | 0 hold, 1 post-increment, 2 pre-decrement, 3 hold |
| ptr_addr | output | 16 | Effective address of the selected pointer |
| ptr_x | output | 16 | X pointer value |
| ptr_y | output | 16 | Y pointer value |
| ptr_z | output | 16 | Z pointer value |
| prog_addr | output | 16 | Program-memory lookup address (Z) |
| dp_addr | input | 16 | Data-space address |
| dp_we | input | 1 | Data-space store enable |
| dp_wdata | input | 8 | Data-space store byte |
| dp_rdata | output | 8 | Data-space load byte |
| dp_hit | output | 1 | Address falls inside the file |

## Verification
The pointer-step and hold properties assume that, in the cycle they check, no ALU, word or data-port write touches the file. Each property is guarded on exactly that condition. The properties also assume that every input is at a known level from the first edge after reset. The bench drives every input to a quiet value before releasing reset. It changes inputs only a short time after each rising edge, and it returns all write enables to zero after every scenario, so each guarded step is seen cleanly.

// File: rtl/gpr_pkg.sv
package gpr_pkg;
    localparam int GPR_COUNT = 32;
    localparam int GPR_W     = 8;
    localparam int DADDR_W   = 16;
    localparam int PTR_PAIRS = 3;

    typedef enum logic [1:0] {
        PSEL_X    = 2'd0,
        PSEL_Y    = 2'd1,
        PSEL_Z    = 2'd2,
        PSEL_NONE = 2'd3
    } ptr_sel_e;

    typedef enum logic [1:0] {
        POP_HOLD    = 2'd0,
        POP_POSTINC = 2'd1,
        POP_PREDEC  = 2'd2,
        POP_RSVD    = 2'd3
    } ptr_op_e;
endpackage

// File: rtl/gpr_ptr_unit.sv
module gpr_ptr_unit
    import gpr_pkg::*;
#(
    parameter int AW    = 5,
    parameter int PW    = 16,
    parameter int PBASE = 26
) (
    input  logic [PW-1:0] cur_x,
    input  logic [PW-1:0] cur_y,
    input  logic [PW-1:0] cur_z,
    input  ptr_sel_e      sel,
    input  ptr_op_e       op,
    output logic          upd_en,
    output logic [AW-1:0] lo_idx,
    output logic [PW-1:0] nxt_val,
    output logic [PW-1:0] eff_addr
);
    logic [PW-1:0] cur;

    always_comb begin
        unique case (sel)
            PSEL_X:  cur = cur_x;
            PSEL_Y:  cur = cur_y;
            PSEL_Z:  cur = cur_z;
            default: cur = '0;
        endcase
        upd_en   = (sel != PSEL_NONE) && (op == POP_POSTINC || op == POP_PREDEC);
        lo_idx   = AW'(PBASE + 2 * int'(sel));
        nxt_val  = (op == POP_PREDEC) ? cur - PW'(1) : cur + PW'(1);
        eff_addr = (op == POP_PREDEC) ? cur - PW'(1) : cur;
    end
endmodule

// File: rtl/gpr_data_decode.sv
module gpr_data_decode #(
    parameter int DAW = 16,
    parameter int AW  = 5,
    parameter int NUM = 32
) (
    input  logic [DAW-1:0] dp_addr,
    output logic           hit,
    output logic [AW-1:0]  idx
);
    always_comb begin
        hit = dp_addr < DAW'(NUM);
        idx = dp_addr[AW-1:0];
    end
endmodule

// File: rtl/gpr_file.sv
module gpr_file
    import gpr_pkg::*;
#(
    parameter int NUM_REGS = GPR_COUNT,
    parameter int DW       = GPR_W,
    parameter int DAW      = DADDR_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [$clog2(NUM_REGS)-1:0] rs1_addr,
    output logic [DW-1:0]            rs1_data,
    input  logic [$clog2(NUM_REGS)-1:0] rs2_addr,
    output logic [DW-1:0]            rs2_data,
    input  logic                     wr_en,
    input  logic [$clog2(NUM_REGS)-1:0] wr_addr,
    input  logic [DW-1:0]            wr_data,
    input  logic                     ww_en,
    input  logic [$clog2(NUM_REGS)-2:0] ww_pair,
    input  logic [2*DW-1:0]          ww_data,
    input  logic [1:0]               ptr_sel,
    input  logic [1:0]               ptr_op,
    output logic [2*DW-1:0]          ptr_addr,
    output logic [2*DW-1:0]          ptr_x,
    output logic [2*DW-1:0]          ptr_y,
    output logic [2*DW-1:0]          ptr_z,
    output logic [2*DW-1:0]          prog_addr,
    input  logic [DAW-1:0]           dp_addr,
    input  logic                     dp_we,
    input  logic [DW-1:0]            dp_wdata,
    output logic [DW-1:0]            dp_rdata,
    output logic                     dp_hit
);
    localparam int AW    = $clog2(NUM_REGS);
    localparam int PW    = 2 * DW;
    localparam int PBASE = NUM_REGS - 2 * PTR_PAIRS;

    logic [DW-1:0] file_q [NUM_REGS];

    logic          p_upd;
    logic [AW-1:0] p_lo;
    logic [PW-1:0] p_nxt;
    logic [AW-1:0] dp_idx;

    assign ptr_x     = {file_q[PBASE+1], file_q[PBASE]};
    assign ptr_y     = {file_q[PBASE+3], file_q[PBASE+2]};
    assign ptr_z     = {file_q[PBASE+5], file_q[PBASE+4]};
    assign prog_addr = ptr_z;

    gpr_ptr_unit #(.AW(AW), .PW(PW), .PBASE(PBASE)) u_ptr (
        .cur_x    (ptr_x),
        .cur_y    (ptr_y),
        .cur_z    (ptr_z),
        .sel      (ptr_sel_e'(ptr_sel)),
        .op       (ptr_op_e'(ptr_op)),
        .upd_en   (p_upd),
        .lo_idx   (p_lo),
        .nxt_val  (p_nxt),
        .eff_addr (ptr_addr)
    );

    gpr_data_decode #(.DAW(DAW), .AW(AW), .NUM(NUM_REGS)) u_dec (
        .dp_addr (dp_addr),
        .hit     (dp_hit),
        .idx     (dp_idx)
    );

    // Combinational read ports (old value during a same-cycle write)
    assign rs1_data = file_q[rs1_addr];
    assign rs2_data = file_q[rs2_addr];
    assign dp_rdata = dp_hit ? file_q[dp_idx] : '0;

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        localparam logic [AW-1:0] IDX = AW'(i);
        logic [DW-1:0] q;
        logic [DW-1:0] d;

        // Byte source priority: ALU, word, data store, pointer
        always_comb begin
            d = q;
            if (wr_en && wr_addr == IDX)
                d = wr_data;
            else if (ww_en && ww_pair == IDX[AW-1:1])
                d = IDX[0] ? ww_data[PW-1:DW] : ww_data[DW-1:0];
            else if (dp_we && dp_hit && dp_idx == IDX)
                d = dp_wdata;
            else if (p_upd && p_lo == IDX)
                d = p_nxt[DW-1:0];
            else if (p_upd && (p_lo + AW'(1)) == IDX)
                d = p_nxt[PW-1:DW];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= '0;
            else        q <= d;
        end

        assign file_q[i] = q;

        p_reset_zero_r1: assert property (@(posedge clk) $rose(rst_n) |-> q == '0)
            else $error("register %0d not zero after reset", i);
    end

    logic quiet;
    assign quiet = !wr_en && !ww_en && !(dp_we && dp_hit);

    p_alu_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> file_q[$past(wr_addr)] == $past(wr_data))
        else $error("ALU write lost");

    p_alu_over_ptr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && p_upd && wr_addr == p_lo) |=> file_q[$past(wr_addr)] == $past(wr_data))
        else $error("pointer update beat ALU write");

    p_postinc_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_op == 2'd1 && ptr_sel == 2'd0) |-> ptr_addr == ptr_x)
        else $error("post-increment address wrong");

    p_postinc_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet && ptr_op == 2'd1 && ptr_sel == 2'd0) |=> ptr_x == $past(ptr_x) + PW'(1))
        else $error("post-increment step wrong");

    p_predec_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet && ptr_op == 2'd2 && ptr_sel == 2'd1) |=> ptr_y == $past(ptr_y) - PW'(1))
        else $error("pre-decrement step wrong");

    p_word_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ww_en && !wr_en) |=> file_q[{$past(ww_pair), 1'b0}] == $past(ww_data[DW-1:0]))
        else $error("word write low byte lost");

    p_miss_store_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (dp_we && !dp_hit && !wr_en && !ww_en && !p_upd)
            |=> file_q[$past(dp_idx)] == $past(file_q[dp_idx]))
        else $error("out-of-range store changed file");

    p_idle_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet && (ptr_op == 2'd0 || ptr_op == 2'd3 || ptr_sel == 2'd3))
            |=> ($stable(ptr_x) && $stable(ptr_y) && $stable(ptr_z)))
        else $error("idle pointer changed");
endmodule

// File: tb/tb_gpr_file.sv
module tb_gpr_file;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [4:0]  rs1_addr, rs2_addr, wr_addr;
    logic [7:0]  rs1_data, rs2_data, wr_data, dp_wdata, dp_rdata;
    logic        wr_en, ww_en, dp_we, dp_hit;
    logic [3:0]  ww_pair;
    logic [15:0] ww_data, ptr_addr, ptr_x, ptr_y, ptr_z, prog_addr, dp_addr;
    logic [1:0]  ptr_sel, ptr_op;

    int checks = 0;
    int errors = 0;
    logic [7:0] ref_q [32];

    always #4 clk = ~clk;

    gpr_file dut (
        .clk(clk), .rst_n(rst_n),
        .rs1_addr(rs1_addr), .rs1_data(rs1_data),
        .rs2_addr(rs2_addr), .rs2_data(rs2_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .ww_en(ww_en), .ww_pair(ww_pair), .ww_data(ww_data),
        .ptr_sel(ptr_sel), .ptr_op(ptr_op), .ptr_addr(ptr_addr),
        .ptr_x(ptr_x), .ptr_y(ptr_y), .ptr_z(ptr_z), .prog_addr(prog_addr),
        .dp_addr(dp_addr), .dp_we(dp_we), .dp_wdata(dp_wdata),
        .dp_rdata(dp_rdata), .dp_hit(dp_hit)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle();
        wr_en = 0; ww_en = 0; dp_we = 0; ptr_sel = 2'd3; ptr_op = 2'd0;
        wr_addr = 0; wr_data = 0; ww_pair = 0; ww_data = 0;
        dp_addr = 16'h0100; dp_wdata = 0;
    endtask

    task automatic tick();
        @(posedge clk); #2;
        idle();
        #1;
    endtask

    task automatic check_file(input string req);
        for (int i = 0; i < 32; i += 2) begin
            rs1_addr = 5'(i); rs2_addr = 5'(i + 1); #1;
            check(req, {8'h00, rs1_data}, {8'h00, ref_q[i]});
            check(req, {8'h00, rs2_data}, {8'h00, ref_q[i+1]});
        end
    endtask

    function automatic logic [15:0] ref_ptr(input int lo);
        return {ref_q[lo+1], ref_q[lo]};
    endfunction

    task automatic word_load(input logic [3:0] pair, input logic [15:0] val);
        ww_en = 1; ww_pair = pair; ww_data = val;
        tick();
        ref_q[2*pair] = val[7:0]; ref_q[2*pair+1] = val[15:8];
    endtask

    task automatic t_reset();
        check_file("R1 reset");
        check("R1 ptr_x", ptr_x, 16'h0000);
        check("R1 ptr_z", ptr_z, 16'h0000);
    endtask

    task automatic t_alu_write();
        for (int i = 0; i < 32; i++) begin
            wr_en = 1; wr_addr = 5'(i); wr_data = 8'(i * 7 + 3);
            tick();
            ref_q[i] = 8'(i * 7 + 3);
        end
        check_file("R3 alu write");
    endtask

    task automatic t_read_during_write();
        rs1_addr = 5'd3; rs2_addr = 5'd3;
        wr_en = 1; wr_addr = 5'd3; wr_data = 8'hC4;
        #1;
        check("R2 old value port1", {8'h00, rs1_data}, {8'h00, ref_q[3]});
        check("R2 old value port2", {8'h00, rs2_data}, {8'h00, ref_q[3]});
        tick();
        ref_q[3] = 8'hC4;
        rs1_addr = 5'd3; #1;
        check("R2 new value", {8'h00, rs1_data}, 16'h00C4);
    endtask

    task automatic t_pointer_map();
        word_load(4'd13, 16'hA1B2);
        word_load(4'd14, 16'hC3D4);
        word_load(4'd15, 16'hE5F6);
        check("R4 X map", ptr_x, 16'hA1B2);
        check("R4 Y map", ptr_y, 16'hC3D4);
        check("R4 Z map", ptr_z, 16'hE5F6);
        check("R11 prog addr", prog_addr, 16'hE5F6);
        rs1_addr = 5'd26; rs2_addr = 5'd31; #1;
        check("R4 R26 low byte", {8'h00, rs1_data}, 16'h00B2);
        check("R4 R31 high byte", {8'h00, rs2_data}, 16'h00E5);
        check_file("R8 word load");
    endtask

    task automatic t_postinc();
        word_load(4'd13, 16'h00FF);
        ptr_sel = 2'd0; ptr_op = 2'd1; #1;
        check("R5 post-inc addr", ptr_addr, 16'h00FF);
        tick();
        check("R5 carry into high byte", ptr_x, 16'h0100);
        word_load(4'd13, 16'hFFFF);
        ptr_sel = 2'd0; ptr_op = 2'd1; #1;
        check("R5 post-inc addr at top", ptr_addr, 16'hFFFF);
        tick();
        check("R5 wrap to zero", ptr_x, 16'h0000);
        ref_q[26] = 0; ref_q[27] = 0;
    endtask

    task automatic t_predec();
        word_load(4'd14, 16'h0000);
        ptr_sel = 2'd1; ptr_op = 2'd2; #1;
        check("R6 pre-dec addr", ptr_addr, 16'hFFFF);
        tick();
        check("R6 wrap to FFFF", ptr_y, 16'hFFFF);
        word_load(4'd15, 16'h1200);
        ptr_sel = 2'd2; ptr_op = 2'd2; #1;
        check("R6 pre-dec Z addr", ptr_addr, 16'h11FF);
        tick();
        check("R6 borrow across bytes", ptr_z, 16'h11FF);
        check("R11 prog follows Z", prog_addr, 16'h11FF);
        ref_q[28] = 8'hFF; ref_q[29] = 8'hFF; ref_q[30] = 8'hFF; ref_q[31] = 8'h11;
    endtask

    task automatic t_priority();
        word_load(4'd15, 16'h12FF);
        ptr_sel = 2'd2; ptr_op = 2'd1;
        wr_en = 1; wr_addr = 5'd31; wr_data = 8'hAA;
        tick();
        check("R7 ALU wins high byte, ptr low byte", ptr_z, 16'hAA00);
        ref_q[30] = 8'h00; ref_q[31] = 8'hAA;
        dp_we = 1; dp_addr = 16'h0005; dp_wdata = 8'h11;
        wr_en = 1; wr_addr = 5'd5; wr_data = 8'h22;
        tick();
        ref_q[5] = 8'h22;
        ww_en = 1; ww_pair = 4'd3; ww_data = 16'hBEEF;
        dp_we = 1; dp_addr = 16'h0007; dp_wdata = 8'h55;
        tick();
        ref_q[6] = 8'hEF; ref_q[7] = 8'hBE;
        ww_en = 1; ww_pair = 4'd13; ww_data = 16'h0102;
        ptr_sel = 2'd0; ptr_op = 2'd1;
        tick();
        ref_q[26] = 8'h02; ref_q[27] = 8'h01;
        check("R7 word beats pointer", ptr_x, 16'h0102);
        check_file("R7 priority");
    endtask

    task automatic t_data_port();
        dp_addr = 16'h001F; #1;
        check("R9 hit at 0x1F", {15'd0, dp_hit}, 16'd1);
        check("R9 load at 0x1F", {8'h00, dp_rdata}, {8'h00, ref_q[31]});
        dp_we = 1; dp_addr = 16'h0009; dp_wdata = 8'h5A;
        tick();
        ref_q[9] = 8'h5A;
        dp_addr = 16'h0009; #1;
        check("R9 store then load", {8'h00, dp_rdata}, 16'h005A);
        dp_addr = 16'h0020; #1;
        check("R10 miss at 0x20", {15'd0, dp_hit}, 16'd0);
        check("R10 miss reads zero", {8'h00, dp_rdata}, 16'h0000);
        dp_we = 1; dp_addr = 16'h0020; dp_wdata = 8'h99;
        tick();
        dp_we = 1; dp_addr = 16'h003E; dp_wdata = 8'h77;
        tick();
        check_file("R10 out-of-range store ignored");
    endtask

    task automatic t_idle_ops();
        logic [15:0] x0, y0, z0;
        x0 = ptr_x; y0 = ptr_y; z0 = ptr_z;
        ptr_sel = 2'd0; ptr_op = 2'd3; tick();
        ptr_sel = 2'd3; ptr_op = 2'd1; tick();
        ptr_sel = 2'd2; ptr_op = 2'd0; tick();
        check("R12 X held", ptr_x, x0);
        check("R12 Y held", ptr_y, y0);
        check("R12 Z held", ptr_z, z0);
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #800000;
        checks++; errors++;
        $display("FAIL watchdog actual timeout expected completion");
        finish_run();
    end

    initial begin
        idle();
        rs1_addr = 0; rs2_addr = 0;
        rst_n = 0;
        for (int i = 0; i < 32; i++) ref_q[i] = 8'h00;
        repeat (3) @(posedge clk);
        #2 rst_n = 1;
        #1;
        t_reset();
        t_alu_write();
        t_read_during_write();
        t_pointer_map();
        t_postinc();
        t_predec();
        t_priority();
        t_data_port();
        t_idle_ops();
        finish_run();
    end
endmodule